// File: doc/BRIEF.md
# Bit-Level Pipelined Unsigned Array Multiplier

This block multiplies two unsigned operands in an array of elemental cells, where each cell is a two-input AND gate feeding a full adder. The partial products are summed in rows of cells that keep sum and carry apart. A ripple adder, also built from the same cells, then merges the last sum and carry vectors. Register lines cut both the rows and the merge adder after every `GRAN` cells of logic depth. The array therefore accepts a new operand pair on every clock, and once the pipeline has filled it delivers one full-width product per clock.

Operand bits are not broadcast across the array. The first operand is passed from one pipeline stage to the next. Each bit of the second operand enters through its own skewing delay, so that it reaches its row in the cycle that row needs it. The low product bits are finished one per row. The merge adder produces each high bit in the stage that owns it. Deskewing delays line all of these bits back up into a single parallel word. A valid flag travels next to the data through a chain of the same length, and only that chain is reset.

Top module: `bitpipe_mult`

## Requirements
- R1: When `out_valid` is 1, `product` equals the unsigned product `op_a * op_b` of the pair that was accepted with it. The product is `A_W + B_W` bits wide with no truncation, including the cases where an operand is zero or all ones.
- R2: The latency from an accepted pair to its product is a constant `ceil(B_W/GRAN) + ceil(A_W/GRAN)` clock cycles. This is 16 cycles for the default 8 by 8 array with `GRAN` = 1.
- R3: `out_valid` repeats `in_valid` delayed by exactly the R2 latency. A gap in `in_valid` reappears as a gap of the same length at the output, and pairs presented with `in_valid` low produce no output marked valid.
- R4: While `rst_n` is 0, `out_valid` is 0. It stays 0 after reset is released until the first pair accepted after the release has had time to reach the output.
- R5: A new pair may be presented on every clock. Back-to-back pairs give back-to-back products, and each product is unaffected by its neighbours in the pipeline.
- R6: Any `GRAN` from 1 up to the larger operand width gives the same products, with the latency of R2 for that `GRAN`. Operand widths of 2 or more are accepted, and other values are rejected when the design is elaborated.
- R7: A reset asserted while pairs are in flight cancels them: none of the pairs accepted in the R2 latency window that ends at the reset edge comes out marked valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all register lines capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid chain |
| in_valid | input | 1 | Marks `op_a`/`op_b` as a pair to be multiplied |
| op_a | input | A_W | Unsigned multiplicand |
| op_b | input | B_W | Unsigned multiplier |
| out_valid | output | 1 | Marks `product` as the result of an accepted pair |
| product | output | A_W+B_W | Unsigned full-width product |

## Verification
Small arrays (4 by 5 and 5 by 4) are swept over every operand pair back to back, so every carry pattern of the row cells and of the merge adder is exercised. Several granularities are used, and their stage boundaries fall at different bits of the merge adder. The default 8 by 8 array receives the operand values zero and all ones, walking single bits against an all-ones partner, and random pairs. A walking bit isolates one row or one column of the array, and the all-ones cases make the carry chain ripple through every stage boundary. A randomly gapped valid pattern, a single isolated pulse, and a reset that arrives mid-stream then separate latency errors and valid-chain errors from arithmetic errors.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

   // Integer ceiling division used for stage counts.
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // Row stages of the carry-save array plus stages of the merge adder.
   function automatic int pipe_latency(input int a_w, input int b_w, input int gran);
      return ceil_div(b_w, gran) + ceil_div(a_w, gran);
   endfunction

endpackage

// File: rtl/bpm_cell.sv
// Elemental cell: AND of two operand bits feeding a full adder.
module bpm_cell (
   input  logic op_x,
   input  logic op_y,
   input  logic s_in,
   input  logic c_in,
   output logic s_out,
   output logic c_out
);
   logic pp;

   assign pp    = op_x & op_y;
   assign s_out = pp ^ s_in ^ c_in;
   assign c_out = (pp & s_in) | (pp & c_in) | (s_in & c_in);
endmodule

// File: rtl/bpm_delay.sv
// Plain register chain used for operand skew and result deskew.
module bpm_delay #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("bpm_delay: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0][W-1:0] sr;

   always_ff @(posedge clk) begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
         sr[i] <= sr[i-1];
      end
   end

   assign dout = sr[DEPTH-1];
endmodule

// File: rtl/bpm_csa_array.sv
// Carry-save partial product rows, one cell deep each, with a register
// line after every GRAN rows and after the last row.
module bpm_csa_array
   import bpm_pkg::*;
#(
   parameter int A_W  = 8,
   parameter int B_W  = 8,
   parameter int GRAN = 1
) (
   input  logic           clk,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   output logic [A_W-1:1] sum_o,
   output logic [A_W-1:0] car_o,
   output logic [B_W-1:0] low_o
);
   localparam int NSTG = ceil_div(B_W, GRAN);

   // Multiplicand handed from stage to stage (local communication only).
   for (genvar k = 0; k < NSTG; k++) begin : g_astg
      logic [A_W-1:0] a_q;
      if (k == 0) begin : g_src
         assign a_q = a_in;
      end else begin : g_hop
         bpm_delay #(.W(A_W), .DEPTH(1)) u_hop (
            .clk  (clk),
            .din  (g_astg[k-1].a_q),
            .dout (a_q)
         );
      end
   end

   // Per-bit skew of the multiplier: bit r waits for the stage of row r.
   logic [B_W-1:0] b_sk;
   for (genvar r = 0; r < B_W; r++) begin : g_bskew
      localparam int D = r / GRAN;
      if (D == 0) begin : g_thru
         assign b_sk[r] = b_in[r];
      end else begin : g_dly
         bpm_delay #(.W(1), .DEPTH(D)) u_skew (
            .clk  (clk),
            .din  (b_in[r]),
            .dout (b_sk[r])
         );
      end
   end

   for (genvar r = 0; r < B_W; r++) begin : g_row
      localparam bit RLINE = ((r % GRAN) == GRAN - 1) || (r == B_W - 1);
      localparam int STG   = r / GRAN;

      logic [A_W-1:1] s_i;
      logic [A_W-1:0] c_i;
      logic [B_W-1:0] l_i;
      logic [A_W-1:0] s_sh, ns, nc;
      logic [B_W-1:0] nl;
      logic [A_W-1:1] s_o;
      logic [A_W-1:0] c_o;
      logic [B_W-1:0] l_o;

      if (r == 0) begin : g_first
         assign s_i = '0;
         assign c_i = '0;
         assign l_i = '0;
      end else begin : g_next
         assign s_i = g_row[r-1].s_o;
         assign c_i = g_row[r-1].c_o;
         assign l_i = g_row[r-1].l_o;
      end

      // Previous sums move one weight down relative to this row.
      assign s_sh = {1'b0, s_i};

      for (genvar j = 0; j < A_W; j++) begin : g_cell
         bpm_cell u_cell (
            .op_x  (g_astg[STG].a_q[j]),
            .op_y  (b_sk[r]),
            .s_in  (s_sh[j]),
            .c_in  (c_i[j]),
            .s_out (ns[j]),
            .c_out (nc[j])
         );
      end

      // Bit 0 of this row's sum is product bit r and is finished here.
      assign nl = l_i | (B_W'(ns[0]) << r);

      if (RLINE) begin : g_reg
         always_ff @(posedge clk) begin
            s_o <= ns[A_W-1:1];
            c_o <= nc;
            l_o <= nl;
         end
      end else begin : g_wire
         assign s_o = ns[A_W-1:1];
         assign c_o = nc;
         assign l_o = nl;
      end
   end

   assign sum_o = g_row[B_W-1].s_o;
   assign car_o = g_row[B_W-1].c_o;
   assign low_o = g_row[B_W-1].l_o;
endmodule

// File: rtl/bpm_merge_add.sv
// Ripple-carry merge of the final sum and carry vectors, GRAN bits per
// stage, with input skew and output deskew so all bits leave together.
module bpm_merge_add
   import bpm_pkg::*;
#(
   parameter int W    = 8,
   parameter int SB_W = 8,
   parameter int GRAN = 1
) (
   input  logic            clk,
   input  logic [W-1:0]    x_in,
   input  logic [W-1:0]    y_in,
   input  logic [SB_W-1:0] sb_in,
   output logic [W-1:0]    sum_o,
   output logic [SB_W-1:0] sb_o,
   output logic            cout_o
);
   localparam int NSTG = ceil_div(W, GRAN);

   for (genvar k = 0; k < W; k++) begin : g_bit
      localparam int  STG  = k / GRAN;
      localparam bit  ENDS = (k % GRAN) == GRAN - 1;

      logic xs, ys, ci, s, co;

      if (STG == 0) begin : g_noskew
         assign xs = x_in[k];
         assign ys = y_in[k];
      end else begin : g_skew
         bpm_delay #(.W(2), .DEPTH(STG)) u_skew (
            .clk  (clk),
            .din  ({x_in[k], y_in[k]}),
            .dout ({xs, ys})
         );
      end

      if (k == 0) begin : g_cin0
         assign ci = 1'b0;
      end else begin : g_cin
         assign ci = g_bit[k-1].g_cf.cfw;
      end

      bpm_cell u_cell (
         .op_x  (xs),
         .op_y  (1'b1),
         .s_in  (ys),
         .c_in  (ci),
         .s_out (s),
         .c_out (co)
      );

      if (k == W - 1) begin : g_top
         assign cout_o = co;
      end else if (ENDS) begin : g_cf
         logic cfw;
         always_ff @(posedge clk) cfw <= co;
      end else begin : g_cf
         logic cfw;
         assign cfw = co;
      end

      bpm_delay #(.W(1), .DEPTH(NSTG - STG)) u_deskew (
         .clk  (clk),
         .din  (s),
         .dout (sum_o[k])
      );
   end

   bpm_delay #(.W(SB_W), .DEPTH(NSTG)) u_sb (
      .clk  (clk),
      .din  (sb_in),
      .dout (sb_o)
   );
endmodule

// File: rtl/bitpipe_mult.sv
module bitpipe_mult
   import bpm_pkg::*;
#(
   parameter int A_W  = 8,
   parameter int B_W  = 8,
   parameter int GRAN = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [A_W-1:0]     op_a,
   input  logic [B_W-1:0]     op_b,
   output logic               out_valid,
   output logic [A_W+B_W-1:0] product
);
   localparam int P_W = A_W + B_W;
   localparam int LAT = pipe_latency(A_W, B_W, GRAN);

   if (A_W < 2 || B_W < 2) begin : g_bad_width
      $error("bitpipe_mult: operand widths must be at least 2");
   end
   if (GRAN < 1 || GRAN > ((A_W > B_W) ? A_W : B_W)) begin : g_bad_gran
      $error("bitpipe_mult: GRAN out of range");
   end

   logic [A_W-1:1] csa_sum;
   logic [A_W-1:0] csa_car;
   logic [B_W-1:0] csa_low;
   logic [A_W-1:0] hi_bits;
   logic [B_W-1:0] low_bits;
   logic           mrg_cout;

   bpm_csa_array #(.A_W(A_W), .B_W(B_W), .GRAN(GRAN)) u_rows (
      .clk   (clk),
      .a_in  (op_a),
      .b_in  (op_b),
      .sum_o (csa_sum),
      .car_o (csa_car),
      .low_o (csa_low)
   );

   bpm_merge_add #(.W(A_W), .SB_W(B_W), .GRAN(GRAN)) u_merge (
      .clk    (clk),
      .x_in   ({1'b0, csa_sum}),
      .y_in   (csa_car),
      .sb_in  (csa_low),
      .sum_o  (hi_bits),
      .sb_o   (low_bits),
      .cout_o (mrg_cout)
   );

   assign product = {hi_bits, low_bits};

   // Valid flag follows the data through a chain of equal length.
   logic [LAT-1:0] vld_sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_sh <= '0;
      end else begin
         vld_sh <= {vld_sh[LAT-2:0], in_valid};
      end
   end

   assign out_valid = vld_sh[LAT-1];
endmodule

// File: rtl/bitpipe_mult_chk.sv
module bitpipe_mult_chk
   import bpm_pkg::*;
#(
   parameter int A_W  = 8,
   parameter int B_W  = 8,
   parameter int GRAN = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [A_W-1:0]     op_a,
   input logic [B_W-1:0]     op_b,
   input logic               out_valid,
   input logic [A_W+B_W-1:0] product,
   input logic               mrg_cout
);
   localparam int P_W = A_W + B_W;
   localparam int LAT = pipe_latency(A_W, B_W, GRAN);

   logic [LAT-1:0] ref_v;
   logic [P_W-1:0] ref_p [LAT];
   int unsigned    fill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_v <= '0;
         fill  <= 0;
      end else begin
         ref_v <= {ref_v[LAT-2:0], in_valid};
         if (fill < LAT) fill <= fill + 1;
      end
   end

   always_ff @(posedge clk) begin
      ref_p[0] <= P_W'(op_a) * P_W'(op_b);
      for (int i = 1; i < LAT; i++) begin
         ref_p[i] <= ref_p[i-1];
      end
   end

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == ref_v[LAT-1]); // R3

   AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> product == ref_p[LAT-1]); // R1

   AST_NO_TOP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == LAT) |-> !mrg_cout); // R1

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid); // R4
endmodule

bind bitpipe_mult bitpipe_mult_chk #(.A_W(A_W), .B_W(B_W), .GRAN(GRAN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .out_valid (out_valid),
   .product   (product),
   .mrg_cout  (mrg_cout)
);

// File: tb/bitpipe_mult_tb.sv
// One configuration of the multiplier with its own stimulus and scoreboard.
module bitpipe_mult_hx #(
   parameter int WA = 8,
   parameter int WB = 8,
   parameter int G  = 1
) (
   input  logic clk,
   output logic done,
   output int   n_chk,
   output int   n_err
);
   localparam int LAT = (WB + G - 1) / G + (WA + G - 1) / G; // R2 formula
   localparam int HN  = 64;

   logic              rst_n;
   logic              in_valid;
   logic [WA-1:0]     a;
   logic [WB-1:0]     b;
   logic              out_valid;
   logic [WA+WB-1:0]  p;

   bitpipe_mult #(.A_W(WA), .B_W(WB), .GRAN(G)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_a      (a),
      .op_b      (b),
      .out_valid (out_valid),
      .product   (p)
   );

   logic          hv [HN];
   logic          hr [HN];
   logic [WA-1:0] ha [HN];
   logic [WB-1:0] hb [HN];
   int            cyc;
   string         tag;

   task automatic check_out();
      logic   ev;
      longint ep;
      int     n;
      ev = 1'b0;
      ep = 0;
      if (cyc >= LAT) begin
         n  = cyc - LAT;
         ev = hv[n % HN];
         for (int k = n; k < cyc; k++) begin
            if (hr[k % HN]) ev = 1'b0; // R7 cancellation
         end
         ep = longint'(ha[n % HN]) * longint'(hb[n % HN]);
      end
      n_chk++;
      if (out_valid !== ev) begin
         n_err++;
         $display("FAIL %s R3 valid (%0dx%0d g%0d) cyc %0d: got %b expected %b",
                  tag, WA, WB, G, cyc, out_valid, ev);
      end
      if (ev && out_valid === 1'b1) begin
         n_chk++;
         if (longint'(p) != ep) begin
            n_err++;
            $display("FAIL %s R1 R6 product (%0dx%0d g%0d) cyc %0d: got %0d expected %0d",
                     tag, WA, WB, G, cyc, p, ep);
         end
      end
   endtask

   task automatic step(input bit r, input bit v, input logic [WA-1:0] av,
                       input logic [WB-1:0] bv);
      @(negedge clk);
      if (cyc > 0) check_out();
      hr[cyc % HN] = r;
      hv[cyc % HN] = v;
      ha[cyc % HN] = av;
      hb[cyc % HN] = bv;
      rst_n    = !r;
      in_valid = v;
      a        = av;
      b        = bv;
      cyc++;
   endtask

   initial begin
      done     = 1'b0;
      n_chk    = 0;
      n_err    = 0;
      cyc      = 0;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      a        = '0;
      b        = '0;

      // R4: reset, then idle long enough to cover the whole pipeline
      tag = "R4";
      repeat (3) step(1'b1, 1'b1, '1, '1);
      repeat (LAT + 1) step(1'b0, 1'b0, '0, '0);

      // R5: back-to-back pairs
      tag = "R5";
      if (WA + WB <= 10) begin
         for (int ia = 0; ia < (1 << WA); ia++) begin
            for (int ib = 0; ib < (1 << WB); ib++) begin
               step(1'b0, 1'b1, WA'(ia), WB'(ib));
            end
         end
      end else begin
         step(1'b0, 1'b1, '0, '0);
         step(1'b0, 1'b1, '0, '1);
         step(1'b0, 1'b1, '1, '0);
         step(1'b0, 1'b1, '1, '1);
         for (int i = 0; i < WA; i++) step(1'b0, 1'b1, WA'(1) << i, '1);
         for (int j = 0; j < WB; j++) step(1'b0, 1'b1, '1, WB'(1) << j);
         for (int i = 0; i < WA; i++) step(1'b0, 1'b1, WA'(1) << i, WB'(1) << (i % WB));
         for (int i = 0; i < 1500; i++) step(1'b0, 1'b1, WA'($urandom), WB'($urandom));
      end

      // R3: random gaps in the valid stream
      tag = "R3";
      for (int i = 0; i < 200; i++) step(1'b0, 1'($urandom), WA'($urandom), WB'($urandom));

      // R7: reset while pairs are in flight
      tag = "R7";
      for (int i = 0; i < 5; i++) step(1'b0, 1'b1, WA'($urandom), WB'($urandom));
      step(1'b1, 1'b1, '1, '1);
      for (int i = 0; i < 5; i++) step(1'b0, 1'b1, WA'($urandom), WB'($urandom));

      // R2: one isolated pulse, observed exactly LAT cycles later
      tag = "R2";
      repeat (LAT + 2) step(1'b0, 1'b0, '0, '0);
      step(1'b0, 1'b1, '1, '1);
      repeat (LAT + 3) step(1'b0, 1'b0, '0, '0);

      done = 1'b1;
   end
endmodule

module bitpipe_mult_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk; // 250 MHz

   logic d0, d1, d2, d3;
   int   c0, c1, c2, c3;
   int   e0, e1, e2, e3;

   // R6: several widths and granularities
   bitpipe_mult_hx #(.WA(8), .WB(8), .G(1)) u_h0 (.clk(clk), .done(d0), .n_chk(c0), .n_err(e0));
   bitpipe_mult_hx #(.WA(4), .WB(5), .G(2)) u_h1 (.clk(clk), .done(d1), .n_chk(c1), .n_err(e1));
   bitpipe_mult_hx #(.WA(5), .WB(4), .G(3)) u_h2 (.clk(clk), .done(d2), .n_chk(c2), .n_err(e2));
   bitpipe_mult_hx #(.WA(8), .WB(6), .G(5)) u_h3 (.clk(clk), .done(d3), .n_chk(c3), .n_err(e3));

   initial begin
      bit wd;
      int checks, errors;
      wd = 1'b0;
      fork
         begin
            wait (d0 && d1 && d2 && d3);
         end
         begin
            repeat (100000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      checks = c0 + c1 + c2 + c3;
      errors = e0 + e1 + e2 + e3;
      if (wd) begin
         checks++;
         errors++;
         $display("FAIL watchdog R5 stream stalled: got no completion, expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule